// File: doc/BRIEF.md
# Deferred Speculative Load Fault Tracker

This block keeps one poison bit per general register so that a load hoisted above a branch can run early without raising its fault at once. When such a speculative load faults, the destination register is marked poisoned and no exception appears. The fault becomes visible only when a later check operation names that register. If the program path that consumes the value is never taken, the check never issues and the fault disappears silently.

Poison also travels through arithmetic. An ALU operation that reads a poisoned source marks its destination poisoned instead of faulting, so a single check at the end of a dependent chain can catch it. Successful loads and ordinary register writes clear the bit. A non-speculative load that faults bypasses the mechanism and raises its own exception directly. All exception outputs are registered one-cycle pulses that carry the register index.

Top module: `spec_fault_tracker`

## Requirements
- R1: After reset every poison bit is clear, both exception outputs are low, and a check on any register raises nothing.
- R2: A speculative load (`ld_valid`=1, `ld_spec`=1) with `ld_fault`=1 sets the poison bit of `ld_dst` and raises neither exception.
- R3: A speculative load with `ld_fault`=0 clears the poison bit of `ld_dst`.
- R4: An ordinary register write (`wr_valid`=1) clears the poison bit of `wr_dst`.
- R5: An ALU operation sets the poison bit of `alu_dst` to the OR of the poison bits of `alu_src_a` and `alu_src_b`, and raises no exception.
- R6: A check (`chk_valid`=1) on a poisoned register drives `spec_exc`=1 with `spec_exc_reg`=`chk_reg` exactly one cycle later, for one cycle per check; the poison bit stays set.
- R7: A check on a clean register leaves `spec_exc` low the next cycle and changes no poison bit.
- R8: A non-speculative load (`ld_spec`=0) with `ld_fault`=1 drives `load_exc`=1 with `load_exc_reg`=`ld_dst` one cycle later and leaves that poison bit unchanged; without a fault it clears the bit and raises nothing.
- R9: When several updates name the same register in one cycle, the load wins over the ALU and the ALU over the ordinary write; ALU sources and checks read the poison state from before that cycle's updates.
- R10: A check exception and a non-speculative load exception arising in the same cycle are both reported on their own outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load completes this cycle |
| ld_spec | input | 1 | 1 = speculative load, 0 = ordinary load |
| ld_fault | input | 1 | The load's memory access faulted |
| ld_dst | input | IDX_W (7) | Load destination register |
| alu_valid | input | 1 | An ALU result is written this cycle |
| alu_src_a | input | IDX_W (7) | First ALU source register |
| alu_src_b | input | IDX_W (7) | Second ALU source register |
| alu_dst | input | IDX_W (7) | ALU destination register |
| wr_valid | input | 1 | An ordinary (non-ALU, non-load) register write |
| wr_dst | input | IDX_W (7) | Ordinary write destination |
| chk_valid | input | 1 | A speculative check executes |
| chk_reg | input | IDX_W (7) | Register named by the check |
| spec_exc | output | 1 | Deferred fault raised by a check (one-cycle pulse) |
| spec_exc_reg | output | IDX_W (7) | Register that carried the poison |
| load_exc | output | 1 | Immediate fault from an ordinary load (one-cycle pulse) |
| load_exc_reg | output | IDX_W (7) | Destination of the faulting ordinary load |

## Verification
The two functions that can coincide are a check reading a register and an update (load, ALU or write) changing the same register in the same cycle, together with a check exception and an ordinary-load exception firing at once. The random phase draws most register indices from a small pool so that such collisions occur often, and directed cycles place a write and a check on one register and a faulting ordinary load beside a poisoned check. A bench model applies the fixed priority and the read-before-update rule, and each exception output is compared separately on the following cycle.

// File: rtl/stf_pkg.sv
package stf_pkg;

   // Source chosen for one poison entry in a cycle, highest priority first.
   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_LOAD  = 2'd1,
      UPD_ALU   = 2'd2,
      UPD_WRITE = 2'd3
   } upd_sel_e;

   // A deferred or immediate fault event, registered before leaving the block.
   typedef struct packed {
      logic       hit;
      logic [7:0] idx;
   } fault_evt_t;

   function automatic upd_sel_e pick_update(input logic ld_hit,
                                            input logic alu_hit,
                                            input logic wr_hit);
      upd_sel_e s;
      if (ld_hit)       s = UPD_LOAD;
      else if (alu_hit) s = UPD_ALU;
      else if (wr_hit)  s = UPD_WRITE;
      else              s = UPD_NONE;
      return s;
   endfunction

endpackage

// File: rtl/stf_poison_file.sv
module stf_poison_file
   import stf_pkg::*;
#(
   parameter int NUM_REGS = 128,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_upd_v,
   input  logic [IDX_W-1:0] ld_upd_dst,
   input  logic             ld_upd_val,
   input  logic             alu_v,
   input  logic [IDX_W-1:0] alu_a,
   input  logic [IDX_W-1:0] alu_b,
   input  logic [IDX_W-1:0] alu_dst,
   input  logic             wr_v,
   input  logic [IDX_W-1:0] wr_dst,
   input  logic [IDX_W-1:0] chk_reg,
   output logic             chk_poison
);

   localparam int LAST = NUM_REGS - 1;

   generate
      if (NUM_REGS < 2) begin : g_bad_depth
         $error("stf_poison_file: NUM_REGS must be at least 2");
      end
      if ((1 << IDX_W) < NUM_REGS) begin : g_bad_width
         $error("stf_poison_file: IDX_W too narrow for NUM_REGS");
      end
   endgenerate

   logic [LAST:0] bits;
   logic          alu_poison;

   // Reads see the state held before this cycle's updates.
   assign alu_poison = bits[alu_a] | bits[alu_b];
   assign chk_poison = bits[chk_reg];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
         logic     ld_hit;
         logic     alu_hit;
         logic     wr_hit;
         upd_sel_e sel;

         assign ld_hit  = ld_upd_v && (ld_upd_dst == IDX_W'(i));
         assign alu_hit = alu_v    && (alu_dst    == IDX_W'(i));
         assign wr_hit  = wr_v     && (wr_dst     == IDX_W'(i));

         always_comb sel = pick_update(ld_hit, alu_hit, wr_hit);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bits[i] <= 1'b0;
            end else begin
               unique case (sel)
                  UPD_LOAD:  bits[i] <= ld_upd_val;
                  UPD_ALU:   bits[i] <= alu_poison;
                  UPD_WRITE: bits[i] <= 1'b0;
                  default:   bits[i] <= bits[i];
               endcase
            end
         end
      end
   endgenerate

   AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> (bits == '0)); // R1

   AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_upd_v && ld_upd_val) |=> bits[$past(ld_upd_dst)]); // R2

   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_upd_v && !ld_upd_val) |=> !bits[$past(ld_upd_dst)]); // R3

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_v && !ld_upd_v && !alu_v) |=> !bits[$past(wr_dst)]); // R4

   AST_ALU_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_v && !ld_upd_v && (bits[alu_a] || bits[alu_b])) |=> bits[$past(alu_dst)]); // R5

   AST_ALU_LOSES_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_v && ld_upd_v && (alu_dst == ld_upd_dst)) |=>
         (bits[$past(alu_dst)] == $past(ld_upd_val))); // R9

endmodule

// File: rtl/stf_fault_report.sv
module stf_fault_report
   import stf_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_v,
   input  logic             chk_poison,
   input  logic [IDX_W-1:0] chk_reg,
   input  logic             ld_trap_v,
   input  logic [IDX_W-1:0] ld_trap_dst,
   output logic             spec_exc,
   output logic [IDX_W-1:0] spec_exc_reg,
   output logic             load_exc,
   output logic [IDX_W-1:0] load_exc_reg
);

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("stf_fault_report: IDX_W must be 1..8");
      end
   endgenerate

   fault_evt_t spec_q, load_q;
   fault_evt_t spec_d, load_d;

   always_comb begin
      spec_d     = '0;
      spec_d.hit = chk_v && chk_poison;
      spec_d.idx = 8'(chk_reg);
      load_d     = '0;
      load_d.hit = ld_trap_v;
      load_d.idx = 8'(ld_trap_dst);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spec_q <= '0;
         load_q <= '0;
      end else begin
         spec_q <= spec_d;
         load_q <= load_d;
      end
   end

   assign spec_exc     = spec_q.hit;
   assign spec_exc_reg = spec_q.idx[IDX_W-1:0];
   assign load_exc     = load_q.hit;
   assign load_exc_reg = load_q.idx[IDX_W-1:0];

   AST_CHECK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_poison) |=> (spec_exc && spec_exc_reg == $past(chk_reg))); // R6

   AST_CLEAN_CHECK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && !chk_poison) |=> !spec_exc); // R7

   AST_TRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_trap_v |=> (load_exc && load_exc_reg == $past(ld_trap_dst))); // R8

   AST_BOTH_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_trap_v && chk_v && chk_poison) |=> (spec_exc && load_exc)); // R10

endmodule

// File: rtl/spec_fault_tracker.sv
module spec_fault_tracker
   import stf_pkg::*;
#(
   parameter int NUM_REGS = 128,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic             ld_spec,
   input  logic             ld_fault,
   input  logic [IDX_W-1:0] ld_dst,
   input  logic             alu_valid,
   input  logic [IDX_W-1:0] alu_src_a,
   input  logic [IDX_W-1:0] alu_src_b,
   input  logic [IDX_W-1:0] alu_dst,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] wr_dst,
   input  logic             chk_valid,
   input  logic [IDX_W-1:0] chk_reg,
   output logic             spec_exc,
   output logic [IDX_W-1:0] spec_exc_reg,
   output logic             load_exc,
   output logic [IDX_W-1:0] load_exc_reg
);

   logic ld_upd_v;
   logic ld_upd_val;
   logic ld_trap_v;
   logic chk_poison;

   // Speculative loads always write the bit (fault -> poison, success -> clear).
   // Ordinary loads clear it on success and trap, leaving it untouched, on fault.
   assign ld_upd_v   = ld_valid && (ld_spec || !ld_fault);
   assign ld_upd_val = ld_spec && ld_fault;
   assign ld_trap_v  = ld_valid && !ld_spec && ld_fault;

   stf_poison_file #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_poison (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_upd_v   (ld_upd_v),
      .ld_upd_dst (ld_dst),
      .ld_upd_val (ld_upd_val),
      .alu_v      (alu_valid),
      .alu_a      (alu_src_a),
      .alu_b      (alu_src_b),
      .alu_dst    (alu_dst),
      .wr_v       (wr_valid),
      .wr_dst     (wr_dst),
      .chk_reg    (chk_reg),
      .chk_poison (chk_poison)
   );

   stf_fault_report #(
      .IDX_W (IDX_W)
   ) u_report (
      .clk          (clk),
      .rst_n        (rst_n),
      .chk_v        (chk_valid),
      .chk_poison   (chk_poison),
      .chk_reg      (chk_reg),
      .ld_trap_v    (ld_trap_v),
      .ld_trap_dst  (ld_dst),
      .spec_exc     (spec_exc),
      .spec_exc_reg (spec_exc_reg),
      .load_exc     (load_exc),
      .load_exc_reg (load_exc_reg)
   );

   AST_SPEC_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_spec && !chk_valid) |=> (!spec_exc && !load_exc)); // R2

   AST_NO_CHECK_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !spec_exc); // R7

endmodule

// File: tb/spec_fault_tracker_tb.sv
module spec_fault_tracker_tb;

   localparam int NR = 128;
   localparam int IW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 0, ld_spec = 0, ld_fault = 0;
   logic [IW-1:0] ld_dst = '0;
   logic          alu_valid = 0;
   logic [IW-1:0] alu_src_a = '0, alu_src_b = '0, alu_dst = '0;
   logic          wr_valid = 0;
   logic [IW-1:0] wr_dst = '0;
   logic          chk_valid = 0;
   logic [IW-1:0] chk_reg = '0;
   logic          spec_exc, load_exc;
   logic [IW-1:0] spec_exc_reg, load_exc_reg;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   bit model [NR];

   always #2 clk = ~clk;

   spec_fault_tracker #(.NUM_REGS(NR)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_fault(ld_fault), .ld_dst(ld_dst),
      .alu_valid(alu_valid), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_dst(alu_dst),
      .wr_valid(wr_valid), .wr_dst(wr_dst),
      .chk_valid(chk_valid), .chk_reg(chk_reg),
      .spec_exc(spec_exc), .spec_exc_reg(spec_exc_reg),
      .load_exc(load_exc), .load_exc_reg(load_exc_reg)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Bench-side next-state rule: load > ALU > write; reads use the old state.
   function automatic bit next_bit(input int r, input bit lv, input bit ls, input bit lf,
                                   input int ld, input bit av, input int aa, input int ab,
                                   input int ad, input bit wv, input int wd);
      if (lv && ld == r && (ls || !lf)) return ls && lf;
      if (av && ad == r)                return model[aa] | model[ab];
      if (wv && wd == r)                return 1'b0;
      return model[r];
   endfunction

   // Apply one cycle of inputs at a falling edge, update the model, compare
   // the registered outputs at the following falling edge.
   task automatic cycle(input bit lv, input bit ls, input bit lf, input int ld,
                        input bit av, input int aa, input int ab, input int ad,
                        input bit wv, input int wd, input bit cv, input int cr,
                        input string tag);
      bit    e_spec, e_load;
      bit    nxt [NR];
      string ts, tl;
      ld_valid = lv; ld_spec = ls; ld_fault = lf; ld_dst = IW'(ld);
      alu_valid = av; alu_src_a = IW'(aa); alu_src_b = IW'(ab); alu_dst = IW'(ad);
      wr_valid = wv; wr_dst = IW'(wd);
      chk_valid = cv; chk_reg = IW'(cr);
      e_spec = cv && model[cr];
      e_load = lv && !ls && lf;
      for (int r = 0; r < NR; r++) nxt[r] = next_bit(r, lv, ls, lf, ld, av, aa, ab, ad, wv, wd);
      for (int r = 0; r < NR; r++) model[r] = nxt[r];
      if (tag != "")             begin ts = tag;   tl = tag;  end
      else if (e_spec && e_load) begin ts = "R10"; tl = "R10"; end
      else begin
         ts = e_spec ? "R6" : (cv ? "R7" : (lv && ls ? "R2" : "R9"));
         tl = (lv && ls) ? "R2" : "R8";
      end
      @(negedge clk);
      check(ts, "spec_exc", int'(spec_exc), int'(e_spec));
      if (e_spec) check(ts, "spec_exc_reg", int'(spec_exc_reg), cr);
      check(tl, "load_exc", int'(load_exc), int'(e_load));
      if (e_load) check(tl, "load_exc_reg", int'(load_exc_reg), ld);
   endtask

   task automatic chk_only(input int r, input string tag);
      cycle(0,0,0,0, 0,0,0,0, 0,0, 1,r, tag);
   endtask

   task automatic idle();
      cycle(0,0,0,0, 0,0,0,0, 0,0, 0,0, "");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      for (int r = 0; r < NR; r++) model[r] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, outputs quiet and every register clean
      check("R1", "spec_exc after reset", int'(spec_exc), 0);
      check("R1", "load_exc after reset", int'(load_exc), 0);
      for (int r = 0; r < NR; r++) chk_only(r, "R1");

      // R2: faulting speculative load is silent, then caught by a check (R6)
      cycle(1,1,1,5, 0,0,0,0, 0,0, 0,0, "R2");
      chk_only(5, "R2");
      // R3: successful speculative load clears
      cycle(1,1,0,5, 0,0,0,0, 0,0, 0,0, "R3");
      chk_only(5, "R3");
      // R4: ordinary write clears
      cycle(1,1,1,9, 0,0,0,0, 0,0, 0,0, "R4");
      cycle(0,0,0,0, 0,0,0,0, 1,9, 0,0, "R4");
      chk_only(9, "R4");
      // R5: poison propagates through the ALU, and clean sources give clean result
      cycle(1,1,1,10, 0,0,0,0, 0,0, 0,0, "R5");
      cycle(0,0,0,0, 1,11,10,12, 0,0, 0,0, "R5");
      chk_only(12, "R5");
      cycle(0,0,0,0, 1,11,11,12, 0,0, 0,0, "R5");
      chk_only(12, "R5");
      // R6: back-to-back checks both fire; poison is kept
      chk_only(10, "R6");
      chk_only(10, "R6");
      // R7: a clean check changes nothing, then a check elsewhere stays quiet
      chk_only(11, "R7");
      idle();
      // R8: ordinary load fault traps immediately, poison of 10 unchanged
      cycle(1,0,1,10, 0,0,0,0, 0,0, 0,0, "R8");
      chk_only(10, "R8");
      cycle(1,0,0,10, 0,0,0,0, 0,0, 0,0, "R8");
      chk_only(10, "R8");
      // R9: load beats write on the same register; check reads the old value
      cycle(1,1,1,20, 0,0,0,0, 1,20, 1,20, "R9");
      chk_only(20, "R9");
      cycle(0,0,0,0, 1,20,20,21, 1,21, 0,0, "R9");
      chk_only(21, "R9");
      cycle(1,1,0,21, 1,20,20,21, 0,0, 1,21, "R9");
      chk_only(21, "R9");
      // R10: both exception kinds in one cycle
      cycle(1,0,1,3, 0,0,0,0, 0,0, 1,20, "R10");
      idle();

      // Random mix, indices drawn mostly from a small pool to force collisions
      for (int n = 0; n < 4000; n++) begin
         int p [6];
         for (int k = 0; k < 6; k++)
            p[k] = ($urandom % 4 == 0) ? int'($urandom % NR) : int'($urandom % 6);
         cycle($urandom%10 < 4, $urandom%10 < 7, $urandom%10 < 4, p[0],
               $urandom%10 < 3, p[1], p[2], p[3],
               $urandom%10 < 2, p[4],
               $urandom%10 < 5, p[5], "");
      end
      idle();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule